// File: doc/BRIEF.md
# Embedded Word-Clock Serializer

This block turns a stream of 12-bit parallel words into a single serial data line plus a source-synchronous serial clock. The receiver needs no separate framing wire. Each word is stretched to 14 serial bits by adding two boundary bits. During the boundary, one low pulse of the serial clock is left out. While the clock is held high, the data line makes exactly one transition. A receiver finds the end of each word by spotting that transition.

The block runs from a system clock at twice the serial bit rate. A bit time is two system cycles: the serial clock is low in the first and high in the second. Words arrive through a valid/ready handshake. A new word is taken only while the serializer is idle or in the last cycle of the previous word. This lets a steady supply of words go out back to back with no gap. When no word is waiting, the serial clock rests high and the data line keeps its last level.

Top module: `ewc_serializer`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the block goes idle. From the next cycle on, `ser_clk` is 1, `ser_data` is 0 and `in_ready` is 1.
- R2: Serial bits 1 to 12 carry parallel bits 0 to 11 in that order, so the LSB goes first. Each bit lasts two system cycles.
- R3: Serial bit 13 is the inverse of parallel bit 11, the MSB.
- R4: Serial bit 14 equals parallel bit 11.
- R5: For serial bits 1 to 13, `ser_clk` is 0 in the first cycle of the bit and 1 in the second. The cycle after a word is accepted is the low half of that word's bit 1.
- R6: The low half of bit 14 is suppressed. `ser_clk` therefore stays 1 for three consecutive cycles: the high half of bit 13 and both halves of bit 14. `ser_data` changes exactly once inside that stretch, at the start of bit 14.
- R7: Apart from the R6 boundary transition, `ser_data` never changes in a cycle where `ser_clk` was 1 in the previous cycle and is still 1.
- R8: `in_ready` is 1 when idle and in the final cycle of bit 14, and 0 otherwise. A word offered in that final cycle starts in the very next cycle, with no idle gap.
- R9: When idle and no word is accepted, `ser_clk` is 1 and `ser_data` keeps its previous value.
- R10: The word is captured in the accepting cycle. Later changes on `in_data` do not alter the bits already being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Parallel word offered |
| in_ready | output | 1 | Serializer will take the offered word on this edge |
| in_data | input | 12 | Parallel word, bit 0 sent first |
| ser_clk | output | 1 | Serial bit clock with embedded word boundary |
| ser_data | output | 1 | Serial data line |

## Verification
Two things coincide at the last cycle of a word's bit 14. The handshake for the next word and the boundary clock stretch meet there, and the next word's first low clock phase must follow with no gap. The bench provokes this by holding `in_valid` high across bursts of words. It also drives the opposite case, where a word arrives after the block has gone idle. A behavioural model builds the expected clock and data levels for every cycle from a queue of extended frames. It compares them against the pins on each clock, and each mismatch is reported against the requirement the expected level came from.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

    // Which half of a serial bit time the line is in.
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

    // Boundary pair appended above the data word: {bit14, bit13}.
    function automatic logic [1:0] boundary_pair(input logic msb);
        return {msb, ~msb};
    endfunction

    // Serial clock level for a given half of a given bit inside a frame.
    function automatic logic clk_level(input half_e half, input logic is_final_bit);
        return (half == HALF_HIGH) || is_final_bit;
    endfunction

endpackage

// File: rtl/ewc_bit_timer.sv
module ewc_bit_timer
    import ewc_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 14,
    localparam int unsigned IDX_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    output logic             busy_q,
    output logic [IDX_W-1:0] idx_q,
    output half_e            half_q,
    output logic             busy_n,
    output logic [IDX_W-1:0] idx_n,
    output half_e            half_n,
    output logic             last_cycle
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    assign last_cycle = busy_q && (idx_q == LAST_IDX) && (half_q == HALF_HIGH);

    always_comb begin
        busy_n = busy_q;
        idx_n  = idx_q;
        half_n = half_q;
        if (accept) begin
            busy_n = 1'b1;
            idx_n  = '0;
            half_n = HALF_LOW;
        end else if (busy_q) begin
            if (last_cycle) begin
                busy_n = 1'b0;
            end else if (half_q == HALF_LOW) begin
                half_n = HALF_HIGH;
            end else begin
                half_n = HALF_LOW;
                idx_n  = idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            half_q <= HALF_LOW;
        end else begin
            busy_q <= busy_n;
            idx_q  <= idx_n;
            half_q <= half_n;
        end
    end

    // The bit index never leaves the frame while a word is in flight.
    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q <= LAST_IDX));

    // After the final cycle of a frame with no new word, the timer is idle.
    assert_frame_end_R8: assert property (@(posedge clk) disable iff (rst)
        (last_cycle && !accept) |=> !busy_q);

endmodule

// File: rtl/ewc_word_store.sv
module ewc_word_store
    import ewc_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    localparam int unsigned FRAME_BITS = DATA_W + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [DATA_W-1:0]     din,
    output logic [FRAME_BITS-1:0] frame_q,
    output logic [FRAME_BITS-1:0] frame_n
);

    logic [FRAME_BITS-1:0] extended;

    // Data bits go straight across; the two top bits come from the MSB.
    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_data
            assign extended[g] = din[g];
        end
    endgenerate
    assign extended[FRAME_BITS-1:DATA_W] = boundary_pair(din[DATA_W-1]);

    assign frame_n = load ? extended : frame_q;

    always_ff @(posedge clk) begin
        if (rst) frame_q <= '0;
        else     frame_q <= frame_n;
    end

    // Boundary bits keep their relation to the stored MSB at all times after a load.
    assert_pair_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (frame_q[DATA_W] != frame_q[DATA_W-1]) && (frame_q[FRAME_BITS-1] == frame_q[DATA_W-1]));

endmodule

// File: rtl/ewc_line_drive.sv
module ewc_line_drive
    import ewc_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 14,
    localparam int unsigned IDX_W = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  busy_n,
    input  logic [IDX_W-1:0]      idx_n,
    input  half_e                 half_n,
    input  logic [FRAME_BITS-1:0] frame_n,
    output logic                  ser_clk_q,
    output logic                  ser_data_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic clk_d;
    logic data_d;

    always_comb begin
        if (busy_n) begin
            clk_d  = clk_level(half_n, idx_n == LAST_IDX);
            data_d = frame_n[idx_n];
        end else begin
            clk_d  = 1'b1;
            data_d = ser_data_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_clk_q  <= 1'b1;
            ser_data_q <= 1'b0;
        end else begin
            ser_clk_q  <= clk_d;
            ser_data_q <= data_d;
        end
    end

endmodule

// File: rtl/ewc_serializer.sv
module ewc_serializer
    import ewc_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    localparam int unsigned FRAME_BITS = DATA_W + 2,
    localparam int unsigned IDX_W = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              ser_clk,
    output logic              ser_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic                  accept;
    logic                  busy_q, busy_n, last_cycle;
    logic [IDX_W-1:0]      idx_q, idx_n;
    half_e                 half_q, half_n;
    logic [FRAME_BITS-1:0] frame_q, frame_n;

    assign in_ready = !busy_q || last_cycle;
    assign accept   = in_valid && in_ready;

    ewc_bit_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .busy_q     (busy_q),
        .idx_q      (idx_q),
        .half_q     (half_q),
        .busy_n     (busy_n),
        .idx_n      (idx_n),
        .half_n     (half_n),
        .last_cycle (last_cycle)
    );

    ewc_word_store #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .din     (in_data),
        .frame_q (frame_q),
        .frame_n (frame_n)
    );

    ewc_line_drive #(.FRAME_BITS(FRAME_BITS)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .busy_n     (busy_n),
        .idx_n      (idx_n),
        .half_n     (half_n),
        .frame_n    (frame_n),
        .ser_clk_q  (ser_clk),
        .ser_data_q (ser_data)
    );

    // A newly accepted word opens with a low clock phase.
    assert_start_low_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ser_clk);

    // Inside the boundary the clock stays high and data toggles once.
    assert_boundary_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q == LAST_IDX && half_q == HALF_LOW)
            |-> (ser_clk && $past(ser_clk) && (ser_data != $past(ser_data))));

    // Final bit repeats the stored MSB.
    assert_final_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q == LAST_IDX) |-> (ser_data == frame_q[DATA_W-1]));

    // Idle with nothing accepted: clock high and data held.
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (ser_clk && $stable(ser_data)));

endmodule

// File: tb/test_ewc_serializer.sv
module test_ewc_serializer;

    localparam int DW       = 12;
    localparam int FB       = DW + 2;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          ser_clk;
    logic          ser_data;

    always #10 clk = ~clk;

    ewc_serializer #(.DATA_W(DW)) i_ewc_serializer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .ser_clk  (ser_clk),
        .ser_data (ser_data)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit tag_r10 = 0;

    // Reference model: queue of expected per-cycle levels.
    bit    q_c[$];
    bit    q_d[$];
    string q_tc[$];
    string q_td[$];
    bit    q_b14[$];
    bit    cur_c = 1;
    bit    cur_d = 0;
    string cur_tc = "R1";
    string cur_td = "R1";
    bit    cur_b14 = 0;
    bit    in_reset = 1;

    task automatic push_word(input logic [DW-1:0] w, input bit r10);
        bit ext [FB];
        for (int i = 0; i < DW; i++) ext[i] = w[i];
        ext[DW]   = ~w[DW-1];
        ext[DW+1] = w[DW-1];
        for (int b = 0; b < FB; b++) begin
            for (int h = 0; h < 2; h++) begin
                q_c.push_back((h == 1) || (b == FB - 1));
                q_d.push_back(ext[b]);
                q_tc.push_back(b == FB - 1 ? "R6" : "R5");
                q_td.push_back(r10 ? "R10" : (b == DW ? "R3" : (b == DW + 1 ? "R4" : "R2")));
                q_b14.push_back((b == FB - 1) && (h == 0));
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q_c.delete(); q_d.delete(); q_tc.delete(); q_td.delete(); q_b14.delete();
            cur_c = 1; cur_d = 0; cur_tc = "R1"; cur_td = "R1"; cur_b14 = 0;
            in_reset = 1;
        end else begin
            in_reset = 0;
            if (in_valid && q_c.size() == 0) push_word(in_data, tag_r10);
            if (q_c.size() > 0) begin
                cur_c = q_c.pop_front(); cur_d = q_d.pop_front();
                cur_tc = q_tc.pop_front(); cur_td = q_td.pop_front();
                cur_b14 = q_b14.pop_front();
            end else begin
                cur_c = 1; cur_tc = "R9"; cur_td = "R9"; cur_b14 = 0;
            end
        end
        started = 1;
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    bit prev_c = 1;
    bit prev_d = 0;

    always @(negedge clk) begin
        cycles++;
        if (started) begin
            bit exp_rdy;
            exp_rdy = (q_c.size() == 0);
            check(ser_clk == cur_c, cur_tc, "ser_clk", ser_clk, cur_c);
            check(ser_data == cur_d, cur_td, "ser_data", ser_data, cur_d);
            check(in_ready == exp_rdy, in_reset ? "R1" : "R8", "in_ready", in_ready, exp_rdy);
            if (!in_reset && prev_c && ser_clk && (ser_data != prev_d))
                check(cur_b14, "R7", "data change while clock high", 1, 0);
            prev_c = ser_clk;
            prev_d = ser_data;
        end
        if (cycles >= WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Offer one word and wait until the edge that accepts it.
    task automatic send_word(input logic [DW-1:0] w);
        bit acc;
        in_valid = 1'b1;
        in_data  = w;
        do begin
            acc = in_ready;
            @(posedge clk); #1;
        end while (!acc);
    endtask

    task automatic idle_cycles(input int n);
        in_valid = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) begin @(posedge clk); #1; end
        rst = 1'b0;                                  // R1 checked during and after reset
        idle_cycles(4);                              // R9 idle levels
        send_word(12'hFFF); idle_cycles(30);         // R3 R4 all ones
        send_word(12'h555); idle_cycles(32);         // R2 alternating
        send_word(12'h000); idle_cycles(30);
        send_word(12'hA5C); idle_cycles(35);
        // Back-to-back burst across the R8 handoff cycle.
        send_word(12'h800);
        send_word(12'h7FF);
        send_word(12'h123);
        send_word(12'hFED);
        idle_cycles(40);
        // R10: change in_data right after acceptance.
        tag_r10 = 1;
        send_word(12'h3C9);
        tag_r10 = 0;
        in_data = 12'hC36;
        idle_cycles(40);
        // Valid held while busy must not be taken early (R8).
        send_word(12'h0F0);
        send_word(12'h00F);
        in_valid = 1'b0;
        idle_cycles(10);
        // Reset in the middle of a word (R1).
        send_word(12'hAAA);
        idle_cycles(9);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        idle_cycles(6);
        send_word(12'h801); idle_cycles(35);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule